// File: doc/BRIEF.md
# Discrete-Sync Video Capture Parser

This block takes a parallel 16-bit YUV 4:2:2 pixel bus, one pixel per clock, with separate horizontal sync, vertical sync, data-enable and field-ID pins. All of these are sampled on the rising edge of the pixel clock. A static style input chooses how lines are found. In HSYNC style, a line is the run of samples between the end of one active horizontal sync pulse and the start of the next. In ACTVID style, a line is each run of samples during which data-enable is active. A frame starts at the first line that begins after vertical sync becomes active. Each sync pin has its own active-level input.

The block puts out a cleaned pixel stream: the pixel word unchanged, a valid flag, start-of-frame, start-of-line and end-of-line markers, and the field bit. When each new frame starts, it reports the width and height it measured for the frame just finished, with a one-cycle strobe. On progressive sources the field pin is expected to read 0. A high level seen at a frame start raises a configuration-error flag. Scaling, colour conversion, memory transfer, embedded-sync decoding and multi-channel input are handled elsewhere.

Top module: `vidSyncCapture`

## Requirements
- R1: The sync pins are sampled on the rising clock edge. Each pin's active level is set by its own configuration bit: 1 means active-high, 0 means active-low. The usual setting is horizontal sync active-low, vertical sync active-low and data-enable active-high.
- R2: With `cfgStyleActvid`=0 (HSYNC style), a line is every sample taken while horizontal sync is inactive. The line starts at the first such sample after an active one. Data-enable has no effect in this style.
- R3: With `cfgStyleActvid`=1 (ACTVID style), a line is every sample taken while data-enable is active. A new line starts on each inactive-to-active change. Horizontal sync has no effect in this style.
- R4: A frame starts at the first line start that coincides with or follows an inactive-to-active change of vertical sync. The first pixel of that line carries `outSof` together with `outSol`.
- R5: From reset until the first frame start, no pixel is output (`outValid` stays 0).
- R6: Every captured pixel appears two clocks after it is sampled, with `outValid`=1 and its data unchanged. The first pixel of each line carries `outSol` and the last carries `outEol`.
- R7: At every frame start except the first after reset, `sizeValid` pulses for one cycle. At the same time `frameWidth` shows the pixel count of the previous frame's last line and `frameHeight` shows the number of lines that frame contained.
- R8: Width and height counts saturate at 4095 and do not wrap.
- R9: `outFid` carries the sampled field pin with each pixel. `fidError` is updated at each frame start: it goes to 1 if the field pin was high on that frame's first pixel and to 0 otherwise.
- R10: A raster of 1600 active pixels in a 2160-sample line is measured as 1600 wide in both styles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStyleActvid | input | 1 | 0: HSYNC-delimited lines, 1: data-enable-delimited lines |
| cfgHsActHigh | input | 1 | Horizontal sync active level (1 = high) |
| cfgVsActHigh | input | 1 | Vertical sync active level (1 = high) |
| cfgAvActHigh | input | 1 | Data-enable active level (1 = high) |
| pixIn | input | 16 | YUV 4:2:2 pixel word |
| hsyncIn | input | 1 | Horizontal sync pin |
| vsyncIn | input | 1 | Vertical sync pin |
| actvidIn | input | 1 | Data-enable pin |
| fidIn | input | 1 | Field-ID pin |
| outValid | output | 1 | Captured pixel present |
| outData | output | 16 | Captured pixel word |
| outSof | output | 1 | First pixel of a frame |
| outSol | output | 1 | First pixel of a line |
| outEol | output | 1 | Last pixel of a line |
| outFid | output | 1 | Field bit of the pixel |
| fidError | output | 1 | Field pin was high at the last frame start |
| sizeValid | output | 1 | One-cycle strobe: size outputs updated |
| frameWidth | output | 12 | Measured width of the previous frame |
| frameHeight | output | 12 | Measured height of the previous frame |

## Verification
A wrong frame-pending or capturing state shows up within one line. Either pixels leak out before the first start-of-frame marker, or the start-of-frame marker lands on the wrong line. Both are visible at the ports within about two clocks of that line's first sample. A wrong line-edge decision in either style shows up at the next frame start, when `frameWidth` and `frameHeight` are reported. The same error also appears inside each line, because the pixel words no longer count up from zero between the start and end markers. The saturation and field-error paths are driven at their limits, and their effect shows in the size values or the flag on the next frame boundary.

// File: rtl/cap_pkg.sv
package cap_pkg;
  // Per-sample decisions from the control to the datapath.
  typedef struct packed {
    logic lineNow;    // current sample lies inside a line
    logic pixKeep;    // current sample is a captured pixel
    logic startKeep;  // current sample opens a captured line
    logic lineEnd;    // previous sample closed a captured line
    logic frameStart; // current sample opens a frame
    logic latchSize;  // a finished frame's size is ready to report
  } capStrobe_t;
endpackage

// File: rtl/capSampler.sv
module capSampler #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgHsActHigh,
  input  logic              cfgVsActHigh,
  input  logic              cfgAvActHigh,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              actvidIn,
  input  logic              fidIn,
  output logic [DATA_W-1:0] sData,
  output logic              sFid,
  output logic              sHs,
  output logic              sVs,
  output logic              sAv,
  output logic              dHs,
  output logic              dVs,
  output logic              dAv
);
  // Normalised syncs: 1 means active regardless of pin polarity.
  // Reset values are chosen so that no edge appears right after reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sData <= '0;
      sFid  <= 1'b0;
      sHs   <= 1'b1;
      sVs   <= 1'b1;
      sAv   <= 1'b0;
      dHs   <= 1'b1;
      dVs   <= 1'b1;
      dAv   <= 1'b0;
    end else begin
      sData <= pixIn;
      sFid  <= fidIn;
      sHs   <= ~(hsyncIn ^ cfgHsActHigh);
      sVs   <= ~(vsyncIn ^ cfgVsActHigh);
      sAv   <= ~(actvidIn ^ cfgAvActHigh);
      dHs   <= sHs;
      dVs   <= sVs;
      dAv   <= sAv;
    end
  end
endmodule

// File: rtl/capLineCtrl.sv
module capLineCtrl
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgStyleActvid,
  input  logic       sHs,
  input  logic       sVs,
  input  logic       sAv,
  input  logic       dHs,
  input  logic       dVs,
  input  logic       dAv,
  output capStrobe_t strobe
);
  logic pending, capturing;
  logic lineNow, linePrev, lineStart, vsRise, pendNow, frameStart, capNext;

  always_comb begin
    lineNow    = cfgStyleActvid ? sAv : ~sHs;
    linePrev   = cfgStyleActvid ? dAv : ~dHs;
    lineStart  = lineNow & ~linePrev;
    vsRise     = sVs & ~dVs;
    pendNow    = pending | vsRise;
    frameStart = lineStart & pendNow;
    capNext    = capturing | frameStart;

    strobe.lineNow    = lineNow;
    strobe.pixKeep    = lineNow & capNext;
    strobe.startKeep  = lineStart & capNext;
    strobe.lineEnd    = linePrev & ~lineNow & capturing;
    strobe.frameStart = frameStart;
    strobe.latchSize  = frameStart & capturing;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      capturing <= 1'b0;
    end else begin
      pending   <= pendNow & ~frameStart;
      capturing <= capNext;
    end
  end

  // Once a frame has begun, capture never stops.
  assert_capture_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    capturing |=> capturing);

  // A latched size report is only possible once capture is running.
  assert_report_after_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchSize |-> capturing);
endmodule

// File: rtl/capSizeMeter.sv
module capSizeMeter
  import cap_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  output logic             sizeValid,
  output logic [CNT_W-1:0] frameWidth,
  output logic [CNT_W-1:0] frameHeight
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lineCnt, lastWidth, heightCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt     <= '0;
      lastWidth   <= '0;
      heightCnt   <= '0;
      sizeValid   <= 1'b0;
      frameWidth  <= '0;
      frameHeight <= '0;
    end else begin
      sizeValid <= strobe.latchSize;
      if (strobe.latchSize) begin
        frameWidth  <= lastWidth;
        frameHeight <= heightCnt;
      end
      if (strobe.startKeep)
        lineCnt <= CNT_W'(1);
      else if (strobe.pixKeep && lineCnt != CNT_MAX)
        lineCnt <= lineCnt + 1'b1;
      if (strobe.lineEnd)
        lastWidth <= lineCnt;
      if (strobe.frameStart)
        heightCnt <= CNT_W'(1);
      else if (strobe.startKeep && heightCnt != CNT_MAX)
        heightCnt <= heightCnt + 1'b1;
    end
  end

  assert_width_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lineCnt == CNT_MAX && !strobe.startKeep) |=> lineCnt == CNT_MAX);

  assert_height_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (heightCnt == CNT_MAX && !strobe.frameStart) |=> heightCnt == CNT_MAX);

  assert_size_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    sizeValid |=> !sizeValid);
endmodule

// File: rtl/capPixelPath.sv
module capPixelPath
  import cap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [DATA_W-1:0] sData,
  input  logic              sFid,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSof,
  output logic              outSol,
  output logic              outEol,
  output logic              outFid,
  output logic              fidError
);
  logic              keep2, sol2, sof2, fid2;
  logic [DATA_W-1:0] data2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keep2    <= 1'b0;
      sol2     <= 1'b0;
      sof2     <= 1'b0;
      fid2     <= 1'b0;
      data2    <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outSol   <= 1'b0;
      outEol   <= 1'b0;
      outFid   <= 1'b0;
      fidError <= 1'b0;
    end else begin
      keep2    <= strobe.pixKeep;
      sol2     <= strobe.startKeep;
      sof2     <= strobe.frameStart;
      fid2     <= sFid;
      data2    <= sData;
      outValid <= keep2;
      outData  <= data2;
      outSof   <= sof2;
      outSol   <= sol2;
      // The held pixel ends its line when the newer sample is outside one.
      outEol   <= keep2 & ~strobe.lineNow;
      outFid   <= fid2;
      if (sof2)
        fidError <= fid2;
    end
  end

  assert_sof_marks_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outSol && outValid));

  assert_eol_closes_line_R6: assert property (@(posedge clk) disable iff (!rstN)
    outEol |=> (!outValid || outSol));

  assert_line_contiguous_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSol) |-> $past(outValid));
endmodule

// File: rtl/vidSyncCapture.sv
module vidSyncCapture
  import cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStyleActvid,
  input  logic              cfgHsActHigh,
  input  logic              cfgVsActHigh,
  input  logic              cfgAvActHigh,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              actvidIn,
  input  logic              fidIn,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSof,
  output logic              outSol,
  output logic              outEol,
  output logic              outFid,
  output logic              fidError,
  output logic              sizeValid,
  output logic [CNT_W-1:0]  frameWidth,
  output logic [CNT_W-1:0]  frameHeight
);
  logic [DATA_W-1:0] sData;
  logic              sFid, sHs, sVs, sAv, dHs, dVs, dAv;
  capStrobe_t        strobe;

  capSampler #(.DATA_W(DATA_W)) sampler (
    .clk(clk), .rstN(rstN),
    .cfgHsActHigh(cfgHsActHigh), .cfgVsActHigh(cfgVsActHigh), .cfgAvActHigh(cfgAvActHigh),
    .pixIn(pixIn), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .actvidIn(actvidIn), .fidIn(fidIn),
    .sData(sData), .sFid(sFid), .sHs(sHs), .sVs(sVs), .sAv(sAv),
    .dHs(dHs), .dVs(dVs), .dAv(dAv)
  );

  capLineCtrl ctrl (
    .clk(clk), .rstN(rstN), .cfgStyleActvid(cfgStyleActvid),
    .sHs(sHs), .sVs(sVs), .sAv(sAv), .dHs(dHs), .dVs(dVs), .dAv(dAv),
    .strobe(strobe)
  );

  capPixelPath #(.DATA_W(DATA_W)) pixPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sData(sData), .sFid(sFid),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outSol(outSol),
    .outEol(outEol), .outFid(outFid), .fidError(fidError)
  );

  capSizeMeter #(.CNT_W(CNT_W)) meter (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sizeValid(sizeValid), .frameWidth(frameWidth), .frameHeight(frameHeight)
  );
endmodule

// File: tb/vidSyncCapture_test.sv
module vidSyncCapture_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgStyleActvid = 1'b0;
  logic        cfgHsActHigh = 1'b0;
  logic        cfgVsActHigh = 1'b0;
  logic        cfgAvActHigh = 1'b1;
  logic [15:0] pixIn = '0;
  logic        hsyncIn = 1'b1;
  logic        vsyncIn = 1'b1;
  logic        actvidIn = 1'b0;
  logic        fidIn = 1'b0;
  logic        outValid, outSof, outSol, outEol, outFid, fidError, sizeValid;
  logic [15:0] outData;
  logic [11:0] frameWidth, frameHeight;

  vidSyncCapture uut (
    .clk(clk), .rstN(rstN), .cfgStyleActvid(cfgStyleActvid),
    .cfgHsActHigh(cfgHsActHigh), .cfgVsActHigh(cfgVsActHigh), .cfgAvActHigh(cfgAvActHigh),
    .pixIn(pixIn), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .actvidIn(actvidIn), .fidIn(fidIn),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outSol(outSol),
    .outEol(outEol), .outFid(outFid), .fidError(fidError), .sizeValid(sizeValid),
    .frameWidth(frameWidth), .frameHeight(frameHeight)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit hsStuck = 1'b0;

  // Output monitor.
  int pixInLine, preSof, sofCnt, solCnt, eolCnt, sizeCnt, dataErr, lastLen, gotW, gotH;
  bit seenSof, lastFid;

  task automatic clearMon();
    pixInLine = 0; preSof = 0; sofCnt = 0; solCnt = 0; eolCnt = 0; sizeCnt = 0;
    dataErr = 0; lastLen = 0; gotW = -1; gotH = -1; seenSof = 1'b0; lastFid = 1'b0;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (outValid) begin
        if (outSol) pixInLine = 1; else pixInLine++;
        if (!seenSof && !outSof) preSof++;
        if (outSof) begin seenSof = 1'b1; sofCnt++; lastFid = outFid; end
        if (outSol) solCnt++;
        if (outData != 16'(pixInLine - 1)) dataErr++;
        if (outEol) begin eolCnt++; lastLen = pixInLine; end
      end
      if (sizeValid) begin sizeCnt++; gotW = int'(frameWidth); gotH = int'(frameHeight); end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < WATCHDOG) @(negedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
    finishRun();
  end

  // Drive one sample: activity flags are converted to pin levels by polarity.
  task automatic setPins(bit hsAct, bit vsAct, bit avAct, logic [15:0] d, bit f);
    hsyncIn  = hsStuck ? 1'b0 : (hsAct ? cfgHsActHigh : ~cfgHsActHigh);
    vsyncIn  = vsAct ? cfgVsActHigh : ~cfgVsActHigh;
    actvidIn = avAct ? cfgAvActHigh : ~cfgAvActHigh;
    pixIn    = d;
    fidIn    = f;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) setPins(1'b1, 1'b0, 1'b0, 16'hdead, 1'b0);
  endtask

  task automatic driveLines(int lines, int active, int lastActive, int blank, bit f);
    for (int l = 0; l < lines; l++) begin
      for (int b = 0; b < blank; b++) setPins(1'b1, 1'b0, 1'b0, 16'hbeef, f);
      for (int c = 0; c < ((l == lines - 1) ? lastActive : active); c++)
        setPins(1'b0, 1'b0, 1'b1, 16'(c), f);
    end
  endtask

  task automatic driveFrame(int lines, int active, int lastActive, int blank, bit f);
    for (int i = 0; i < 6; i++) setPins(1'b1, 1'b1, 1'b0, 16'h5a5a, f);
    driveLines(lines, active, lastActive, blank, f);
  endtask

  task automatic doReset(bit style, bit hsPol, bit vsPol, bit avPol);
    rstN = 1'b0;
    cfgStyleActvid = style; cfgHsActHigh = hsPol; cfgVsActHigh = vsPol; cfgAvActHigh = avPol;
    hsStuck = 1'b0;
    idle(4);
    clearMon();
    rstN = 1'b1;
    idle(2);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idle(3);
    check(outValid == 1'b0, "R5", "outValid in reset", int'(outValid), 0);
    check(sizeValid == 1'b0, "R7", "sizeValid in reset", int'(sizeValid), 0);
    check(fidError == 1'b0, "R9", "fidError in reset", int'(fidError), 0);
    check(frameWidth == 12'd0, "R7", "frameWidth in reset", int'(frameWidth), 0);
  endtask

  // HSYNC style with default polarities; data-enable held inactive.
  task automatic testHsyncStyle();
    doReset(1'b0, 1'b0, 1'b0, 1'b1);
    for (int l = 0; l < 2; l++) begin
      for (int b = 0; b < 8; b++) setPins(1'b1, 1'b0, 1'b0, 16'h1111, 1'b0);
      for (int c = 0; c < 20; c++) setPins(1'b0, 1'b0, 1'b0, 16'(c), 1'b0);
    end
    idle(4);
    check(preSof == 0 && solCnt == 0, "R5", "pixels before first frame", preSof + solCnt, 0);
    for (int fr = 0; fr < 3; fr++) begin
      for (int i = 0; i < 6; i++) setPins(1'b1, 1'b1, 1'b0, 16'h5a5a, 1'b0);
      for (int l = 0; l < 3; l++) begin
        for (int b = 0; b < 8; b++) setPins(1'b1, 1'b0, 1'b0, 16'hbeef, 1'b0);
        for (int c = 0; c < 20; c++) setPins(1'b0, 1'b0, 1'b0, 16'(c), 1'b0);
      end
    end
    idle(8);
    check(sofCnt == 3, "R4", "frame starts", sofCnt, 3);
    check(solCnt == 9, "R2", "line starts", solCnt, 9);
    check(eolCnt == 9, "R6", "line ends", eolCnt, 9);
    check(dataErr == 0, "R6", "pixel data order", dataErr, 0);
    check(sizeCnt == 2, "R7", "size reports", sizeCnt, 2);
    check(gotW == 20, "R2", "width in HSYNC style", gotW, 20);
    check(gotH == 3, "R7", "height", gotH, 3);
  endtask

  // ACTVID style, inverted polarities, HSYNC pin stuck, short last line.
  task automatic testActvidStyle();
    doReset(1'b1, 1'b1, 1'b1, 1'b0);
    hsStuck = 1'b1;
    for (int fr = 0; fr < 3; fr++) driveFrame(4, 33, 27, 7, 1'b0);
    idle(8);
    check(sofCnt == 3, "R3", "frame starts, ACTVID style", sofCnt, 3);
    check(solCnt == 12, "R3", "line starts, ACTVID style", solCnt, 12);
    check(gotW == 27, "R7", "width from last line", gotW, 27);
    check(gotH == 4, "R1", "height with inverted polarities", gotH, 4);
    check(lastLen == 27, "R6", "last line length at outEol", lastLen, 27);
    check(dataErr == 0, "R6", "pixel data, ACTVID style", dataErr, 0);
  endtask

  task automatic testUxga(bit style);
    doReset(style, 1'b0, 1'b0, 1'b1);
    for (int fr = 0; fr < 3; fr++) driveFrame(3, 1600, 1600, 560, 1'b0);
    idle(8);
    check(gotW == 1600, "R10", style ? "UXGA width ACTVID" : "UXGA width HSYNC", gotW, 1600);
    check(gotH == 3, "R10", "UXGA line count", gotH, 3);
  endtask

  task automatic testWidthSat();
    doReset(1'b1, 1'b0, 1'b0, 1'b1);
    for (int fr = 0; fr < 3; fr++) driveFrame(2, 4200, 4200, 6, 1'b0);
    idle(8);
    check(gotW == 4095, "R8", "width saturates", gotW, 4095);
    check(lastLen == 4200, "R6", "pixels still delivered past limit", lastLen, 4200);
  endtask

  task automatic testHeightSat();
    doReset(1'b1, 1'b0, 1'b0, 1'b1);
    for (int fr = 0; fr < 2; fr++) driveFrame(4100, 1, 1, 1, 1'b0);
    driveFrame(1, 3, 3, 2, 1'b0);
    idle(8);
    check(gotH == 4095, "R8", "height saturates", gotH, 4095);
  endtask

  task automatic testFid();
    doReset(1'b1, 1'b0, 1'b0, 1'b1);
    driveFrame(2, 10, 10, 4, 1'b0);
    idle(4);
    check(fidError == 1'b0, "R9", "fidError, field pin low", int'(fidError), 0);
    driveFrame(2, 10, 10, 4, 1'b1);
    idle(4);
    check(fidError == 1'b1, "R9", "fidError, field pin high", int'(fidError), 1);
    check(lastFid == 1'b1, "R9", "outFid at frame start", int'(lastFid), 1);
    driveFrame(2, 10, 10, 4, 1'b0);
    idle(4);
    check(fidError == 1'b0, "R9", "fidError cleared", int'(fidError), 0);
  endtask

  initial begin
    clearMon();
    testReset();
    testHsyncStyle();
    testActvidStyle();
    testUxga(1'b0);
    testUxga(1'b1);
    testWidthSat();
    testHeightSat();
    testFid();
    finishRun();
  end
endmodule